// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Coherent Two-Byte Read

This block keeps a 12-bit count that steps once per microsecond and wraps silently. A prescaler divides the system clock (12 cycles per step by default) into a single-cycle tick that advances the count. Two timer taps give a one-cycle pulse each time a chosen count bit goes from 0 to 1. By default these are bit 7, one pulse per 256 µs period (128 µs after each roll of the lower bits), and bit 10, one pulse per 2.048 ms.

Software reads the count in two byte-wide accesses, each signalled by a one-cycle strobe. A low-byte strobe returns count bits 7:0. In the same cycle it copies count bits 11:8 into a holding register. A later high-byte strobe returns that held nibble, not the live upper bits. The two halves therefore always come from the same instant, even when the count carries between the two accesses. Read data appears on `rdData` one cycle after the strobe and stays there until the next strobe.

Top module: `usec_timer`

## Requirements
- R1: An active-low `rstN` clears the count, the prescaler, the holding nibble and `rdData` to zero, and both taps are low while it is asserted and in the first cycle after it is released.
- R2: The count advances by exactly one every 12 clock cycles. With reset released just before edge 0, the first increment happens on the 12th rising edge.
- R3: The count wraps from 0xFFF to 0x000 with no other indication.
- R4: A `rdLowStb` sampled high at a rising edge loads `rdData` with count bits 7:0 as they stood before that edge. At the same edge it stores count bits 11:8 into the holding nibble.
- R5: A `rdHighStb` sampled high (with `rdLowStb` low) loads `rdData` with the holding nibble in bits 3:0 and zeros in bits 7:4. It never uses the live upper count bits.
- R6: When both strobes are high at the same edge, the low-byte read is served and the holding nibble is updated.
- R7: With neither strobe high, `rdData` keeps its value.
- R8: `tapFast` is high for exactly one cycle, the cycle after the tick that makes count bit 7 go from 0 to 1. That gives 16 pulses per 4096 ticks.
- R9: `tapSlow` is high for exactly one cycle, the cycle after the tick that makes count bit 10 go from 0 to 1. That gives 2 pulses per 4096 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdLowStb | input | 1 | One-cycle strobe: read low byte and capture the upper nibble |
| rdHighStb | input | 1 | One-cycle strobe: read the held upper nibble |
| rdData | output | 8 | Registered read data |
| tapFast | output | 1 | Pulse on each rise of count bit 7 |
| tapSlow | output | 1 | Pulse on each rise of count bit 10 |

## Verification
The properties assume that the strobes change only between clock edges and that the prescale ratio is at least two, so that ticks never fall on back-to-back cycles. Under that assumption a tap pulse can never last two cycles and always follows a tick. The stimulus drives every strobe on the falling edge and drops it after one cycle, except in the deliberate two-cycle read that pins down the first-tick timing. The high-nibble carry case is set up by capturing the low byte at 0x1FF and then reading the nibble after the live count has moved to 0x2xx.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic tick;        // advance the count this edge
    logic captureLow;  // load low byte, snapshot upper bits
    logic serveHigh;   // load held upper bits
  } timerStrobes_t;
endpackage

// File: rtl/usec_timer_ctrl.sv
module usec_timer_ctrl
  import usec_timer_pkg::*;
#(
  parameter int CLK_PER_TICK = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdLowStb,
  input  logic          rdHighStb,
  output timerStrobes_t strb
);
  localparam int PRE_W = (CLK_PER_TICK > 2) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_TICK - 1);

  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (preCnt == PRE_LAST) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  // Low-byte read has priority when both strobes coincide
  always_comb begin
    strb.tick       = (preCnt == PRE_LAST);
    strb.captureLow = rdLowStb;
    strb.serveHigh  = rdHighStb & ~rdLowStb;
  end
endmodule

// File: rtl/usec_timer_dp.sv
module usec_timer_dp
  import usec_timer_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int RD_W     = 8,
  parameter int FAST_BIT = 7,
  parameter int SLOW_BIT = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  timerStrobes_t   strb,
  output logic [RD_W-1:0] rdData,
  output logic            tapFast,
  output logic            tapSlow
);
  localparam int HOLD_W = CNT_W - RD_W;
  localparam int NTAP   = 2;

  logic [CNT_W-1:0]  count;
  logic [HOLD_W-1:0] holdHi;
  logic [NTAP-1:0]   tapNow, tapPrev, tapPulse;

  function automatic int tapBit(input int idx);
    return (idx == 0) ? FAST_BIT : SLOW_BIT;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.tick) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdHi <= '0;
      rdData <= '0;
    end else if (strb.captureLow) begin
      rdData <= count[RD_W-1:0];
      holdHi <= count[CNT_W-1:RD_W];
    end else if (strb.serveHigh) begin
      rdData <= {{(RD_W-HOLD_W){1'b0}}, holdHi};
    end
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign tapNow[t] = count[tapBit(t)];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tapPrev[t] <= 1'b0;
      end else begin
        tapPrev[t] <= tapNow[t];
      end
    end
    assign tapPulse[t] = tapNow[t] & ~tapPrev[t];
  end

  assign tapFast = tapPulse[0];
  assign tapSlow = tapPulse[1];
endmodule

// File: rtl/usec_timer.sv
module usec_timer
  import usec_timer_pkg::*;
#(
  parameter int CLK_PER_TICK = 12,
  parameter int CNT_W        = 12,
  parameter int RD_W         = 8,
  parameter int FAST_BIT     = 7,
  parameter int SLOW_BIT     = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rdLowStb,
  input  logic            rdHighStb,
  output logic [RD_W-1:0] rdData,
  output logic            tapFast,
  output logic            tapSlow
);
  timerStrobes_t strb;

  usec_timer_ctrl #(.CLK_PER_TICK(CLK_PER_TICK)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdLowStb (rdLowStb),
    .rdHighStb(rdHighStb),
    .strb     (strb)
  );

  usec_timer_dp #(
    .CNT_W   (CNT_W),
    .RD_W    (RD_W),
    .FAST_BIT(FAST_BIT),
    .SLOW_BIT(SLOW_BIT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdData (rdData),
    .tapFast(tapFast),
    .tapSlow(tapSlow)
  );
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk #(
  parameter int RD_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            rdLowStb,
  input logic            rdHighStb,
  input logic            tick,
  input logic [RD_W-1:0] rdData,
  input logic            tapFast,
  input logic            tapSlow
);
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (rdData == '0) && !tapFast && !tapSlow);

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  a_r5_high_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdHighStb && !rdLowStb) |=> (rdData[RD_W-1:4] == '0));

  a_r7_data_held: assert property (@(posedge clk) disable iff (!rstN)
    (!rdLowStb && !rdHighStb) |=> $stable(rdData));

  a_r8_fast_single: assert property (@(posedge clk) disable iff (!rstN)
    tapFast |=> !tapFast);

  a_r8_fast_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    tapFast |-> $past(tick));

  a_r9_slow_single: assert property (@(posedge clk) disable iff (!rstN)
    tapSlow |=> !tapSlow);

  a_r9_slow_after_tick: assert property (@(posedge clk) disable iff (!rstN)
    tapSlow |-> $past(tick));
endmodule

bind usec_timer usec_timer_chk #(.RD_W(RD_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdLowStb (rdLowStb),
  .rdHighStb(rdHighStb),
  .tick     (strb.tick),
  .rdData   (rdData),
  .tapFast  (tapFast),
  .tapSlow  (tapSlow)
);

// File: tb/usec_timer_tb.sv
module usec_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdLowStb = 1'b0;
  logic       rdHighStb = 1'b0;
  logic [7:0] rdData;
  logic       tapFast, tapSlow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usec_timer u_dut (
    .clk(clk), .rstN(rstN), .rdLowStb(rdLowStb), .rdHighStb(rdHighStb),
    .rdData(rdData), .tapFast(tapFast), .tapSlow(tapSlow)
  );

  // Reference model built from the requirements
  int         mPre;
  logic [11:0] mCnt, mPrev;
  logic [3:0]  mHold;
  logic [7:0]  mRd;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPre <= 0; mCnt <= '0; mPrev <= '0; mHold <= '0; mRd <= '0;
    end else begin
      mPrev <= mCnt;
      if (mPre == 11) begin
        mPre <= 0; mCnt <= mCnt + 12'd1;
      end else begin
        mPre <= mPre + 1;
      end
      if (rdLowStb) begin
        mRd <= mCnt[7:0]; mHold <= mCnt[11:8];
      end else if (rdHighStb) begin
        mRd <= {4'h0, mHold};
      end
    end
  end
  wire expFast = mCnt[7] & ~mPrev[7];
  wire expSlow = mCnt[10] & ~mPrev[10];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 rdData in reset", {24'h0, rdData}, 32'h0);
    check("R1 taps in reset", {30'h0, tapFast, tapSlow}, 32'h0);
    rstN = 1'b1;
  endtask

  task automatic readLow(output logic [7:0] val);
    rdLowStb = 1'b1; @(negedge clk); rdLowStb = 1'b0; val = rdData;
  endtask

  task automatic readHigh(output logic [7:0] val);
    rdHighStb = 1'b1; @(negedge clk); rdHighStb = 1'b0; val = rdData;
  endtask

  task automatic waitCount(input logic [11:0] v);
    while (mCnt != v) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    doReset();
    @(negedge clk);
    check("R1 rdData after release", {24'h0, rdData}, 32'h0);
    readHigh(v);
    check("R1 hold cleared", {24'h0, v}, 32'h0);
  endtask

  task automatic t_first_tick();
    doReset();
    // released at this negedge; next rising edge is edge 1
    repeat (11) @(negedge clk);
    rdLowStb = 1'b1;
    @(negedge clk);          // edge 12 captured pre-increment value
    check("R2 count before 12th edge", {24'h0, rdData}, 32'h0);
    @(negedge clk);          // edge 13 captured after first increment
    rdLowStb = 1'b0;
    check("R2 count after 12th edge", {24'h0, rdData}, 32'h1);
    repeat (10) @(negedge clk);
    rdLowStb = 1'b1; @(negedge clk); rdLowStb = 1'b0;   // edge 24
    check("R2 still one before edge 24", {24'h0, rdData}, 32'h1);
    rdLowStb = 1'b1; @(negedge clk); rdLowStb = 1'b0;   // edge 25
    check("R2 two after edge 24", {24'h0, rdData}, 32'h2);
  endtask

  task automatic t_latch();
    logic [7:0] v;
    waitCount(12'h1FF);
    readLow(v);
    check("R4 low byte at 0x1FF", {24'h0, v}, 32'hFF);
    waitCount(12'h205);
    readHigh(v);
    check("R5 held nibble not live", {24'h0, v}, 32'h1);
    readLow(v);
    check("R4 low byte model", {24'h0, v}, {24'h0, mRd});
    readHigh(v);
    check("R5 new nibble", {24'h0, v}, 32'h2);
  endtask

  task automatic t_both();
    logic [7:0] v;
    logic [11:0] snap;
    waitCount(12'h3A0);
    snap = mCnt;
    rdLowStb = 1'b1; rdHighStb = 1'b1; @(negedge clk);
    rdLowStb = 1'b0; rdHighStb = 1'b0;
    check("R6 both strobes low wins", {24'h0, rdData}, {24'h0, snap[7:0]});
    readHigh(v);
    check("R6 hold updated", {24'h0, v}, {28'h0, snap[11:8]});
  endtask

  task automatic t_idle();
    logic [7:0] v0;
    v0 = rdData;
    repeat (40) @(negedge clk);
    check("R7 rdData held while idle", {24'h0, rdData}, {24'h0, v0});
  endtask

  task automatic t_taps();
    int fastN = 0, slowN = 0, fastBad = 0, slowBad = 0;
    for (int i = 0; i < 12 * 4096; i++) begin
      @(negedge clk);
      if (tapFast !== expFast) fastBad++;
      if (tapSlow !== expSlow) slowBad++;
      if (tapFast) fastN++;
      if (tapSlow) slowN++;
    end
    check("R8 fast tap alignment mismatches", fastBad, 0);
    check("R8 fast pulses per wrap", fastN, 16);
    check("R9 slow tap alignment mismatches", slowBad, 0);
    check("R9 slow pulses per wrap", slowN, 2);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    waitCount(12'hFFF);
    readLow(v);
    check("R3 low at top", {24'h0, v}, 32'hFF);
    readHigh(v);
    check("R3 high at top", {24'h0, v}, 32'hF);
    waitCount(12'h000);
    readLow(v);
    check("R3 low after wrap", {24'h0, v}, 32'h0);
    readHigh(v);
    check("R3 high after wrap", {24'h0, v}, 32'h0);
  endtask

  task automatic t_reset_mid();
    logic [7:0] v;
    waitCount(12'h034);
    readLow(v);
    doReset();
    @(negedge clk);
    readHigh(v);
    check("R1 hold cleared mid-run", {24'h0, v}, 32'h0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    t_reset();
    t_first_tick();
    t_latch();
    t_both();
    t_idle();
    t_taps();
    t_wrap();
    t_reset_mid();
    finishRun();
  end
endmodule